// File: doc/BRIEF.md
# Pixel Bit-Depth Reducer with Random Spatial Dither

This block narrows a 12-bit-per-channel RGB pixel stream to 6, 8 or 10 significant bits per channel. It keeps the output word 12 bits wide and MSB-aligned, and it forces the discarded low bits to zero. It can cut the low bits off directly, or it can first add a pseudo-random value to the bits it is about to drop. The random value comes from 28-bit shift-register generators, one for each colour channel, and the output saturates instead of wrapping.

All control fields are plain input ports. The block captures them on the start-of-frame pulse, so a whole frame runs under one setting. A small frame counter can perturb the generator seed at every frame start, so that the dither pattern changes from frame to frame. Each output is registered once, with one cycle from a valid input pixel to the matching output.

Top module: `pix_depth_reducer`

## Requirements
- R1: While reset is held (synchronous, active-low `rst_n`), `out_valid` is 0, all three output channels are 0 and the frame counter is 0.
- R2: `out_valid` equals `in_valid` of the previous cycle. While `in_valid` is low, the output channel values do not change.
- R3: The control fields (`trunc_en`, `trunc_deep`, `dith_en`, `dith_depth`, `frame_rand`, `rgb_rand`) are captured in a cycle with `sof`=1, and the pixel in that same cycle already uses them. Changes in other cycles have no effect until the next `sof`. Before the first `sof` all fields act as 0.
- R4: With `dith_en`=0 and `trunc_en`=0, each output channel equals its input channel one cycle later.
- R5: With `dith_en`=0 and `trunc_en`=1, `trunc_deep`=0 clears the low 6 bits (6 bits kept) and `trunc_deep`=1 clears the low 4 bits (8 bits kept).
- R6: With `dith_en`=1 (this overrides truncation), D = 6 for `dith_depth`=0, D = 4 for 1, and D = 2 for 2 or 3. The low D bits of the channel's generator state are added to the input. The sum is limited to 4095, and then its low D bits are cleared.
- R7: Each generator is a 28-bit register that steps as next = {s[26:0], s[27] XOR s[2]} (polynomial x^28+x^3+1). It steps once per valid pixel. The pixel uses the state held before the step.
- R8: A seed load sets each generator to its seed XOR the rotated frame counter (in bits 3:0), or to 1 if that result is 0. The pixel in the load cycle already uses the loaded value.
- R9: With `frame_rand`=1 the generators load at every `sof`. With `frame_rand`=0 they load only at the first `sof` after reset and then run freely across frames.
- R10: At a `sof` with `frame_rand`=1, the 4-bit frame counter advances by one. It returns to 0 from 15 or above (`dith_depth` 0 or 1), or from 3 or above (`dith_depth` 2 or 3). At a `sof` with `frame_rand`=0 it is cleared. The load uses the counter value from before the update.
- R11: Before the XOR into the seed, the counter is rotated left within 4 bits: by 2 for `dith_depth` 0 or 1, and by 1 for `dith_depth` 2 or 3.
- R12: With `rgb_rand`=1, each channel takes noise from its own generator. With `rgb_rand`=0, all three channels use the red generator, and the green and blue seeds have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse; captures controls |
| in_valid | input | 1 | Input pixel qualifier |
| in_r | input | 12 | Red input |
| in_g | input | 12 | Green input |
| in_b | input | 12 | Blue input |
| trunc_en | input | 1 | Truncation enable |
| trunc_deep | input | 1 | Truncation depth: 0 keeps 6 bits, 1 keeps 8 |
| dith_en | input | 1 | Random dither enable |
| dith_depth | input | 2 | Dither depth code |
| frame_rand | input | 1 | Reseed at every frame with counter perturbation |
| rgb_rand | input | 1 | Independent noise per channel |
| seed_r | input | 28 | Red generator seed |
| seed_g | input | 28 | Green generator seed |
| seed_b | input | 28 | Blue generator seed |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | 12 | Reduced red |
| out_g | output | 12 | Reduced green |
| out_b | output | 12 | Reduced blue |

## Verification
Three things can happen in one cycle: the start-of-frame capture of new controls, the seed load, and the use of the generator by a valid pixel. The bench therefore puts the first pixel of every frame in the `sof` cycle. It then checks that this pixel's value reflects both the newly captured mode and the freshly loaded seed, not the previous frame's settings or running state. Saturation is exercised alongside the dither add on full-scale inputs, and the frame counter is carried through both wrap points by running long frame sequences.

// File: rtl/pdr_pkg.sv
// Shared types and helpers for the pixel bit-depth reducer.
// Assumes a 4-bit frame counter; wrap points and rotations are fixed codes.
package pdr_pkg;

    localparam int FC_W = 4;

    typedef struct packed {
        logic       trunc_en;
        logic       trunc_deep;
        logic       dith_en;
        logic [1:0] dith_depth;
        logic       frame_rand;
        logic       rgb_rand;
    } pdr_cfg_t;

    // Counter wrap value for a dither depth code.
    function automatic logic [FC_W-1:0] fc_wrap(input logic [1:0] depth);
        return depth[1] ? FC_W'(3) : FC_W'(15);
    endfunction

    // Counter rotation amount for a dither depth code.
    function automatic logic [1:0] fc_rot(input logic [1:0] depth);
        return depth[1] ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/pdr_lfsr.sv
// One noise generator: 28-bit shift register, x^28 + x^3 + 1.
// A load takes priority and is visible on cur in the same cycle; a zero
// load value is replaced by 1 so the register can never lock up.
module pdr_lfsr #(
    parameter int W   = 28,
    parameter int TAP = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] cur
);
    logic [W-1:0] st;
    logic [W-1:0] seed_fix;

    // Replace an all-zero seed with 1.
    assign seed_fix = (load_val == '0) ? W'(1) : load_val;
    // Value seen by the pixel of this cycle.
    assign cur = load ? seed_fix : st;

    // State register: advance once per valid pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= W'(1);
        else if (step)
            st <= {cur[W-2:0], cur[W-1] ^ cur[TAP-1]};
        else
            st <= cur;
    end
endmodule

// File: rtl/pdr_frame_ctl.sv
// Frame counter and seed-load control.
// Assumes controls presented here are already the active (frame) ones.
module pdr_frame_ctl
    import pdr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof,
    input  logic            frame_rand,
    input  logic [1:0]      dith_depth,
    output logic            load,
    output logic [FC_W-1:0] mix,
    output logic [FC_W-1:0] fc_q
);
    logic                seeded;
    logic [2*FC_W-1:0]   dbl;

    // Rotate the counter left within FC_W bits.
    always_comb begin
        dbl = {fc_q, fc_q} << fc_rot(dith_depth);
        mix = frame_rand ? dbl[2*FC_W-1:FC_W] : '0;
    end

    // Reload at every frame when randomised, else only the first time.
    assign load = sof && (frame_rand || !seeded);

    // Counter update and first-frame flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fc_q   <= '0;
            seeded <= 1'b0;
        end else if (sof) begin
            seeded <= 1'b1;
            if (!frame_rand)
                fc_q <= '0;
            else if (fc_q >= fc_wrap(dith_depth))
                fc_q <= '0;
            else
                fc_q <= fc_q + 1'b1;
        end
    end
endmodule

// File: rtl/pdr_chan.sv
// One channel: add masked noise, saturate, clear dropped bits, register.
// Assumes noise is zero when dither is off and drop <= PIX_W.
module pdr_chan #(
    parameter int PIX_W  = 12,
    parameter int DROP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [PIX_W-1:0]  pix,
    input  logic [PIX_W-1:0]  noise,
    input  logic [DROP_W-1:0] drop,
    output logic [PIX_W-1:0]  pix_q
);
    logic [PIX_W-1:0] keep_mask;
    logic [PIX_W:0]   sum;
    logic [PIX_W-1:0] sat;

    // Saturating add of the low noise bits, then clear the dropped bits.
    always_comb begin
        keep_mask = {PIX_W{1'b1}} << drop;
        sum       = {1'b0, pix} + {1'b0, noise & ~keep_mask};
        sat       = sum[PIX_W] ? {PIX_W{1'b1}} : sum[PIX_W-1:0];
    end

    // Output register, updated only by valid pixels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_q <= '0;
        else if (valid)
            pix_q <= sat & keep_mask;
    end
endmodule

// File: rtl/pix_depth_reducer.sv
// Top: captures controls at frame start, runs three generators and three
// channel reducers. Assumes PIX_W >= 10 and LFSR_W >= PIX_W.
module pix_depth_reducer
    import pdr_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LFSR_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    input  logic              trunc_en,
    input  logic              trunc_deep,
    input  logic              dith_en,
    input  logic [1:0]        dith_depth,
    input  logic              frame_rand,
    input  logic              rgb_rand,
    input  logic [LFSR_W-1:0] seed_r,
    input  logic [LFSR_W-1:0] seed_g,
    input  logic [LFSR_W-1:0] seed_b,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);
    localparam int NCH    = 3;
    localparam int DROP_W = $clog2(PIX_W + 1);
    localparam int DROP6  = PIX_W - 6;
    localparam int DROP8  = PIX_W - 8;
    localparam int DROP10 = PIX_W - 10;

    pdr_cfg_t          cfg_in, cfg_hold, cfg_act;
    logic [DROP_W-1:0] act_drop;
    logic              gen_load;
    logic [FC_W-1:0]   fc_mix;
    logic [FC_W-1:0]   fc_val;
    logic [LFSR_W-1:0] seed_arr [NCH];
    logic [LFSR_W-1:0] gen_cur  [NCH];
    logic [PIX_W-1:0]  pix_in   [NCH];
    logic [PIX_W-1:0]  pix_out  [NCH];

    // Gather the control ports into one record.
    assign cfg_in = '{trunc_en:   trunc_en,   trunc_deep: trunc_deep,
                      dith_en:    dith_en,    dith_depth: dith_depth,
                      frame_rand: frame_rand, rgb_rand:   rgb_rand};

    // The frame-start pixel already sees the new controls.
    assign cfg_act = sof ? cfg_in : cfg_hold;

    // Hold the controls for the rest of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_hold <= '0;
        else if (sof)
            cfg_hold <= cfg_in;
    end

    // Number of low bits discarded in the active mode.
    always_comb begin
        if (cfg_act.dith_en) begin
            case (cfg_act.dith_depth)
                2'd0:    act_drop = DROP_W'(DROP6);
                2'd1:    act_drop = DROP_W'(DROP8);
                default: act_drop = DROP_W'(DROP10);
            endcase
        end else if (cfg_act.trunc_en)
            act_drop = cfg_act.trunc_deep ? DROP_W'(DROP8) : DROP_W'(DROP6);
        else
            act_drop = '0;
    end

    // Valid pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    pdr_frame_ctl u_fctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (sof),
        .frame_rand (cfg_act.frame_rand),
        .dith_depth (cfg_act.dith_depth),
        .load       (gen_load),
        .mix        (fc_mix),
        .fc_q       (fc_val)
    );

    assign seed_arr[0] = seed_r;
    assign seed_arr[1] = seed_g;
    assign seed_arr[2] = seed_b;
    assign pix_in[0]   = in_r;
    assign pix_in[1]   = in_g;
    assign pix_in[2]   = in_b;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [PIX_W-1:0] noise;

        pdr_lfsr #(.W(LFSR_W)) u_gen (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (gen_load),
            .load_val (seed_arr[ch] ^ LFSR_W'(fc_mix)),
            .step     (in_valid),
            .cur      (gen_cur[ch])
        );

        // Pick own or shared (red) noise; zero when dither is off.
        always_comb begin
            if (!cfg_act.dith_en)
                noise = '0;
            else if (cfg_act.rgb_rand)
                noise = gen_cur[ch][PIX_W-1:0];
            else
                noise = gen_cur[0][PIX_W-1:0];
        end

        pdr_chan #(.PIX_W(PIX_W), .DROP_W(DROP_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (in_valid),
            .pix   (pix_in[ch]),
            .noise (noise),
            .drop  (act_drop),
            .pix_q (pix_out[ch])
        );
    end

    assign out_r = pix_out[0];
    assign out_g = pix_out[1];
    assign out_b = pix_out[2];
endmodule

// File: rtl/pix_depth_reducer_chk.sv
// Property checker for pix_depth_reducer, attached by bind below.
module pix_depth_reducer_chk #(
    parameter int PIX_W  = 12,
    parameter int LFSR_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sof,
    input logic              in_valid,
    input logic [PIX_W-1:0]  in_r,
    input logic [PIX_W-1:0]  in_g,
    input logic [PIX_W-1:0]  in_b,
    input logic              out_valid,
    input logic [PIX_W-1:0]  out_r,
    input logic [PIX_W-1:0]  out_g,
    input logic [PIX_W-1:0]  out_b,
    input logic [$clog2(PIX_W+1)-1:0] act_drop,
    input logic              act_frame_rand,
    input logic [1:0]        act_depth,
    input logic [3:0]        fc_val,
    input logic [LFSR_W-1:0] gen_r
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                    // R2
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                  // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b))); // R2
    AST_PASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && act_drop == '0) |=>
        (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b))); // R4
    AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_r & ~({PIX_W{1'b1}} << $past(act_drop))) == '0)); // R5
    AST_FC_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && act_frame_rand && act_depth[1]) |=> (fc_val <= 4'd3)); // R10
    AST_FC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && !act_frame_rand) |=> (fc_val == 4'd0));             // R10
    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        gen_r != '0);                                               // R8
endmodule

bind pix_depth_reducer pix_depth_reducer_chk #(.PIX_W(PIX_W), .LFSR_W(LFSR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sof            (sof),
    .in_valid       (in_valid),
    .in_r           (in_r),
    .in_g           (in_g),
    .in_b           (in_b),
    .out_valid      (out_valid),
    .out_r          (out_r),
    .out_g          (out_g),
    .out_b          (out_b),
    .act_drop       (act_drop),
    .act_frame_rand (cfg_act.frame_rand),
    .act_depth      (cfg_act.dith_depth),
    .fc_val         (fc_val),
    .gen_r          (gen_cur[0])
);

// File: tb/pix_depth_reducer_test.sv
module pix_depth_reducer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0, in_valid = 1'b0;
    logic [11:0] in_r = '0, in_g = '0, in_b = '0;
    logic        trunc_en = 0, trunc_deep = 0, dith_en = 0, frame_rand = 0, rgb_rand = 0;
    logic [1:0]  dith_depth = 0;
    logic [27:0] seed_r = '0, seed_g = '0, seed_b = '0;
    logic        out_valid;
    logic [11:0] out_r, out_g, out_b;

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference state
    logic [27:0] m_gen [3];
    logic [3:0]  m_fc;
    bit          m_seeded;
    bit          h_te, h_td, h_de, h_fr, h_rr;
    logic [1:0]  h_dd;

    pix_depth_reducer uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] rot4(input logic [3:0] v, input int r);
        return (r == 2) ? {v[1:0], v[3:2]} : {v[2:0], v[3]};
    endfunction

    function automatic logic [11:0] reduce(input int pix, input int noise, input int d);
        int p2 = 1 << d;
        int s = pix + (noise % p2);
        if (s > 4095) s = 4095;
        return 12'(s - (s % p2));
    endfunction

    // Drive one pixel, advance the reference, and check the result.
    task automatic send(input bit f, input logic [11:0] r, g, b, input string req);
        logic [11:0] e [3];
        logic [11:0] px [3];
        int d;
        px[0] = r; px[1] = g; px[2] = b;
        if (f) begin
            h_te = trunc_en; h_td = trunc_deep; h_de = dith_en;
            h_dd = dith_depth; h_fr = frame_rand; h_rr = rgb_rand;
            if (h_fr || !m_seeded) begin
                logic [3:0] mx;
                logic [27:0] sd [3];
                sd[0] = seed_r; sd[1] = seed_g; sd[2] = seed_b;
                mx = h_fr ? rot4(m_fc, h_dd[1] ? 1 : 2) : 4'd0;
                for (int c = 0; c < 3; c++) begin
                    m_gen[c] = sd[c] ^ {24'd0, mx};
                    if (m_gen[c] == 0) m_gen[c] = 28'd1;
                end
            end
            m_seeded = 1;
            if (!h_fr) m_fc = 0;
            else if (m_fc >= (h_dd[1] ? 4'd3 : 4'd15)) m_fc = 0;
            else m_fc = m_fc + 1;
        end
        if (h_de) d = (h_dd == 0) ? 6 : (h_dd == 1) ? 4 : 2;
        else if (h_te) d = h_td ? 4 : 6;
        else d = 0;
        for (int c = 0; c < 3; c++) begin
            int n = h_de ? int'(m_gen[h_rr ? c : 0][11:0]) : 0;
            e[c] = reduce(int'(px[c]), n, d);
        end
        for (int c = 0; c < 3; c++)
            m_gen[c] = {m_gen[c][26:0], m_gen[c][27] ^ m_gen[c][2]};
        sof = f; in_valid = 1; in_r = r; in_g = g; in_b = b;
        @(negedge clk);
        sof = 0; in_valid = 0;
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " r"}, 32'(out_r), 32'(e[0]));
        chk({req, " g"}, 32'(out_g), 32'(e[1]));
        chk({req, " b"}, 32'(out_b), 32'(e[2]));
    endtask

    task automatic set_cfg(input bit te, td, de, input logic [1:0] dd, input bit fr, rr);
        trunc_en = te; trunc_deep = td; dith_en = de; dith_depth = dd;
        frame_rand = fr; rgb_rand = rr;
    endtask

    task automatic t_reset();   // R1
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 r", 32'(out_r), 0);
        chk("R1 g", 32'(out_g), 0);
        chk("R1 b", 32'(out_b), 0);
    endtask

    task automatic t_pass();    // R4, R3 defaults before first sof
        set_cfg(1, 0, 1, 0, 1, 1);   // ignored: no sof yet
        send(0, 12'h123, 12'hABC, 12'hFFF, "R4 R3 pass");
        send(0, 12'h001, 12'h800, 12'h7FF, "R4 pass");
        chk("R4 explicit", 32'(out_g), 32'h800);
    endtask

    task automatic t_idle();    // R2
        @(negedge clk);
        chk("R2 idle valid", 32'(out_valid), 0);
        chk("R2 hold", 32'(out_g), 32'h800);
    endtask

    task automatic t_dither_explicit();  // R6 R7 R8 R12
        set_cfg(1, 1, 1, 0, 0, 0);
        seed_r = 28'h25; seed_g = 28'h0; seed_b = 28'h7;
        send(1, 12'h81F, 12'h81F, 12'h81F, "R6 R12 shared");
        chk("R6 explicit r", 32'(out_r), 32'h840);
        chk("R12 g uses red noise", 32'(out_g), 32'h840);
        send(0, 12'h834, 12'h834, 12'h834, "R7 step");
        chk("R7 explicit", 32'(out_r), 32'h800);
        send(0, 12'hFFF, 12'hFFF, 12'hFFF, "R6 saturate");
        chk("R6 sat explicit", 32'(out_b), 32'hFC0);
    endtask

    task automatic t_rgb_split();   // R12 R8 (zero seed)
        set_cfg(0, 0, 1, 0, 1, 1);
        send(1, 12'h81F, 12'h81F, 12'h81F, "R12 split");
        chk("R12 r explicit", 32'(out_r), 32'h840);
        chk("R8 zero seed g", 32'(out_g), 32'h800);
        send(0, 12'h3C5, 12'h13A, 12'hEEE, "R12 split 2");
    endtask

    task automatic t_mid_change();  // R3 R5
        set_cfg(1, 0, 0, 0, 0, 0);
        send(0, 12'hABC, 12'hABC, 12'hABC, "R3 mid-frame ignored");
        send(1, 12'hABC, 12'h555, 12'h03F, "R5 trunc6");
        chk("R5 trunc6 explicit", 32'(out_r), 32'hA80);
        set_cfg(1, 1, 0, 0, 0, 0);
        send(1, 12'hABC, 12'h555, 12'h00F, "R5 trunc8");
        chk("R5 trunc8 explicit", 32'(out_r), 32'hAB0);
    endtask

    task automatic t_frames(input logic [1:0] dd, input bit fr, input int n, input string req);
        seed_r = 28'h9A3_C51; seed_g = 28'h123_4567; seed_b = 28'hFED_CBA;
        set_cfg(1, 0, 1, dd, fr, 1);
        for (int k = 0; k < n; k++) begin
            send(1, 12'h7F3, 12'h0FE, 12'hFFD, req);
            send(0, 12'h412, 12'hA5A, 12'h333, req);
        end
    endtask

    initial begin
        m_fc = 0; m_seeded = 0;
        h_te = 0; h_td = 0; h_de = 0; h_dd = 0; h_fr = 0; h_rr = 0;
        for (int c = 0; c < 3; c++) m_gen[c] = 28'd1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_pass();
        t_idle();
        t_dither_explicit();
        t_rgb_split();
        t_mid_change();
        t_frames(2'd0, 1, 18, "R10 R11 long wrap");
        t_frames(2'd2, 1, 7,  "R10 R11 short wrap");
        t_frames(2'd3, 1, 5,  "R6 R11 depth3");
        t_frames(2'd1, 0, 4,  "R9 free run");
        t_frames(2'd1, 1, 3,  "R9 R10 reseed");
        seed_r = 28'd0; seed_g = 28'd0; seed_b = 28'd0;
        set_cfg(1, 1, 1, 2'd0, 0, 1);
        send(1, 12'hFFF, 12'h000, 12'h8C0, "R9 no reload on sof");
        send(0, 12'h001, 12'h002, 12'h003, "R6 priority over trunc");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule